// File: doc/BRIEF.md
# Reference Trim Calibration Controller

This controller trims two internally generated reference levels so that each one matches a precise reference. Each level has its own trim counter, and that counter drives the trim DAC for that level. The controller cannot measure voltages. It uses the system converter instead: it drives a switch-pattern word that sets up the converter's capacitor array, requests a conversion, and reads back the resulting code. In one iteration it converts the precise setting first and the rough setting second, then compares the two codes. If the codes are equal, that level is finished. If they differ, the trim counter moves one step in the direction that closes the gap.

Both trim counters start at their highest value and are normally walked downward. Starting low can produce a matching code before the rough level is really trimmed, because of a one-LSB dead zone near the target. The two levels are calibrated in turn: level B is only touched after level A reports done. When both are done, a normal-operation flag rises, and the two trim values stay frozen until the next reset. If a step would push a counter past zero or past its maximum, the counter does not wrap. Instead the controller raises an error flag and stops.

Top module: `refcal_ctrl`

## Requirements
- R1: During and after a synchronous reset, both trim outputs equal the start value (all ones by default). `pat_bus`, `conv_req`, `ref_done`, `normal_op` and `sat_err` are all zero.
- R2: After reset the controller stays idle and issues no conversion request until `cal_start` is sampled high.
- R3: Each conversion request is a single-cycle pulse on `conv_req`, and `pat_bus[2]` is high while the request is made. `pat_bus[1]` selects the level (0 = A, 1 = B). `pat_bus[0]` is 0 for the precise setting and 1 for the rough setting. Within an iteration, the precise conversion always comes before the rough one, so successive requests alternate between precise and rough, starting with precise. A code is taken from `conv_code` in the cycle where `conv_done` is high.
- R4: When the rough code equals the precise code, that level's `ref_done` bit (bit 0 = A, bit 1 = B) is set and stays set, and its trim value no longer changes.
- R5: When the rough code is above the precise code, the trim of the level under calibration decreases by exactly one. When it is below, the trim increases by exactly one. The other level's trim never changes.
- R6: No request for level B is made before `ref_done[0]` is set. `normal_op` rises only after both done bits are set, and `pat_bus` then returns to zero.
- R7: If a step is needed while the trim is already at zero (stepping down) or at its maximum (stepping up), the trim stays unchanged and `sat_err` is set. After that, no further conversion is requested, `pat_bus` stays zero, and `normal_op` stays low.
- R8: After completion or an error halt, `cal_start` is ignored, and both trim values hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Begins the calibration sequence |
| conv_done | input | 1 | Converter result valid, one cycle |
| conv_code | input | CODE_W (14) | Converter result code |
| conv_req | output | 1 | Conversion request pulse |
| pat_bus | output | 3 | Switch pattern: active, level, rough |
| trim_a | output | TRIM_W (8) | Trim value of level A |
| trim_b | output | TRIM_W (8) | Trim value of level B |
| ref_done | output | 2 | Per-level calibrated flags |
| normal_op | output | 1 | Both levels calibrated |
| sat_err | output | 1 | Trim range exhausted, calibration halted |

## Verification
There are two broad classes of internal fault. The first is a wrong comparison direction or a lost step. This shows up as a trim value that ends somewhere other than the converter model's matching point. It can also appear as a saturation error within a few hundred cycles, because the counter runs off toward the wrong rail. The second is a sequencing fault, such as a swapped pattern phase, level B starting early, or requests continuing after a halt. The pattern monitor catches this at the very next `conv_req` pulse. The alternate-target vector forces an upward step after descending, which exposes a missing increment path in the cycle where the codes first cross.

// File: rtl/refcal_pkg.sv
package refcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CONV_P, ST_CONV_R, ST_EVAL, ST_DONE, ST_HALT
  } cal_state_t;

  localparam int PAT_W     = 3;
  localparam int PAT_ACT   = 2;
  localparam int PAT_LEVEL = 1;
  localparam int PAT_ROUGH = 0;

  function automatic logic [PAT_W-1:0] pat_word(input logic level, input logic rough);
    logic [PAT_W-1:0] w;
    w            = '0;
    w[PAT_ACT]   = 1'b1;
    w[PAT_LEVEL] = level;
    w[PAT_ROUGH] = rough;
    return w;
  endfunction
endpackage

// File: rtl/refcal_trim.sv
module refcal_trim #(
  parameter int           W    = 8,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_min,
  output logic         at_max
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)      q <= INIT;
    else if (dec) q <= q - 1'b1;
    else if (inc) q <= q + 1'b1;
  end

  assign at_min = (q == '0);
  assign at_max = (q == MAXV);

  // R7: sequencer never asks for a step past either rail
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst) dec |-> !at_min);
  a_r7_no_overflow:  assert property (@(posedge clk) disable iff (rst) inc |-> !at_max);
  // R5: trim moves by exactly one per step, in one direction only
  a_r5_one_dir:      assert property (@(posedge clk) disable iff (rst) !(dec && inc));
  a_r5_unit_step:    assert property (@(posedge clk) disable iff (rst)
                       !$stable(q) |-> (q == $past(q) - 1'b1 || q == $past(q) + 1'b1));
endmodule

// File: rtl/refcal_fsm.sv
module refcal_fsm
  import refcal_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic [1:0]        at_min,
  input  logic [1:0]        at_max,
  output logic [1:0]        dec,
  output logic [1:0]        inc,
  output logic              conv_req,
  output logic [PAT_W-1:0]  pat_bus,
  output logic [1:0]        ref_done,
  output logic              normal_op,
  output logic              sat_err
);
  cal_state_t        state;
  logic              level;
  logic [CODE_W-1:0] code_p, code_r;
  logic              match, too_high, blocked;

  assign match    = (code_r == code_p);
  assign too_high = (code_r > code_p);
  assign blocked  = too_high ? at_min[level] : at_max[level];

  always_comb begin
    dec = '0;
    inc = '0;
    if (state == ST_EVAL && !match && !blocked) begin
      if (too_high) dec[level] = 1'b1;
      else          inc[level] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      level     <= 1'b0;
      conv_req  <= 1'b0;
      pat_bus   <= '0;
      code_p    <= '0;
      code_r    <= '0;
      ref_done  <= '0;
      normal_op <= 1'b0;
      sat_err   <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      unique case (state)
        ST_IDLE: if (cal_start) begin
          pat_bus  <= pat_word(1'b0, 1'b0);
          conv_req <= 1'b1;
          state    <= ST_CONV_P;
        end
        ST_CONV_P: if (conv_done) begin
          code_p   <= conv_code;
          pat_bus  <= pat_word(level, 1'b1);
          conv_req <= 1'b1;
          state    <= ST_CONV_R;
        end
        ST_CONV_R: if (conv_done) begin
          code_r <= conv_code;
          state  <= ST_EVAL;
        end
        ST_EVAL: begin
          if (match) begin
            ref_done[level] <= 1'b1;
            if (level) begin
              normal_op <= 1'b1;
              pat_bus   <= '0;
              state     <= ST_DONE;
            end else begin
              level    <= 1'b1;
              pat_bus  <= pat_word(1'b1, 1'b0);
              conv_req <= 1'b1;
              state    <= ST_CONV_P;
            end
          end else if (blocked) begin
            sat_err <= 1'b1;
            pat_bus <= '0;
            state   <= ST_HALT;
          end else begin
            pat_bus  <= pat_word(level, 1'b0);
            conv_req <= 1'b1;
            state    <= ST_CONV_P;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: no request while waiting for the start command
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
                     (state == ST_IDLE) |-> !conv_req);
  // R3: request is a one-cycle pulse made with an active pattern
  a_r3_req_pulse:  assert property (@(posedge clk) disable iff (rst) conv_req |=> !conv_req);
  a_r3_req_active: assert property (@(posedge clk) disable iff (rst) conv_req |-> pat_bus[PAT_ACT]);
  // R4: a done flag never falls
  a_r4_done_a_sticky: assert property (@(posedge clk) disable iff (rst) ref_done[0] |=> ref_done[0]);
  // R6: level B only after level A is done; normal flag needs both
  a_r6_order:      assert property (@(posedge clk) disable iff (rst)
                     (pat_bus[PAT_ACT] && pat_bus[PAT_LEVEL]) |-> ref_done[0]);
  a_r6_normal_both: assert property (@(posedge clk) disable iff (rst)
                     normal_op |-> (ref_done == 2'b11 && pat_bus == '0));
  // R7: halted controller stays silent
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (rst)
                     sat_err |-> (!conv_req && pat_bus == '0 && !normal_op));
endmodule

// File: rtl/refcal_ctrl.sv
module refcal_ctrl
  import refcal_pkg::*;
#(
  parameter int                CODE_W    = 14,
  parameter int                TRIM_W    = 8,
  parameter logic [TRIM_W-1:0] TRIM_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              conv_req,
  output logic [2:0]        pat_bus,
  output logic [TRIM_W-1:0] trim_a,
  output logic [TRIM_W-1:0] trim_b,
  output logic [1:0]        ref_done,
  output logic              normal_op,
  output logic              sat_err
);
  localparam int NLEV = 2;

  logic [NLEV-1:0]   dec, inc, at_min, at_max;
  logic [TRIM_W-1:0] trim_q [NLEV];

  refcal_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cal_start (cal_start),
    .conv_done (conv_done),
    .conv_code (conv_code),
    .at_min    (at_min),
    .at_max    (at_max),
    .dec       (dec),
    .inc       (inc),
    .conv_req  (conv_req),
    .pat_bus   (pat_bus),
    .ref_done  (ref_done),
    .normal_op (normal_op),
    .sat_err   (sat_err)
  );

  for (genvar g = 0; g < NLEV; g++) begin : g_trim
    refcal_trim #(.W(TRIM_W), .INIT(TRIM_INIT)) u_trim (
      .clk    (clk),
      .rst    (rst),
      .dec    (dec[g]),
      .inc    (inc[g]),
      .q      (trim_q[g]),
      .at_min (at_min[g]),
      .at_max (at_max[g])
    );
  end

  assign trim_a = trim_q[0];
  assign trim_b = trim_q[1];

  // R8: trims frozen once calibration has finished or halted
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
               (normal_op || sat_err) |=> ($stable(trim_a) && $stable(trim_b)));
  // R5: only the level under calibration may move
  a_r5_b_idle_first: assert property (@(posedge clk) disable iff (rst)
               !ref_done[0] |=> $stable(trim_b));
endmodule

// File: tb/test_refcal_ctrl.sv
`timescale 1ns/1ps
module test_refcal_ctrl;
  localparam int CODE_W = 14;
  localparam int TRIM_W = 8;
  localparam int TMAX   = 255;
  localparam int TGT_A  = 128;   // 14'b00000010000000
  localparam int TGT_B  = 4096;
  localparam int LAT    = 3;
  localparam int LIMIT  = 20000;

  typedef struct packed {
    int good_a; int good_b; int alt_at; int alt_good;
    int exp_a;  int exp_b;  int exp_done; int exp_norm; int exp_err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{200, 180,  -1,   0, 200, 180, 3, 1, 0},
    '{255,   0,  -1,   0, 255,   0, 3, 1, 0},
    '{100, 150, 101, 104, 104, 150, 3, 1, 0},
    '{ -5, 150,  -1,   0,   0, 255, 0, 0, 1},
    '{120,  -3,  -1,   0, 120,   0, 1, 0, 1},
    '{300, 150,  -1,   0, 255, 255, 0, 0, 1}
  };

  logic clk = 1'b0, rst = 1'b1, cal_start = 1'b0, conv_done = 1'b0;
  logic [CODE_W-1:0] conv_code = '0;
  logic conv_req, normal_op, sat_err;
  logic [2:0] pat_bus;
  logic [TRIM_W-1:0] trim_a, trim_b;
  logic [1:0] ref_done;

  int n_checks = 0, n_fail = 0;
  int cur_ga, cur_gb, cur_alt_at, cur_alt_good;
  bit alt_hit;
  int req_cnt, phase_err;
  bit exp_rough;

  always #2 clk = ~clk;

  refcal_ctrl #(.CODE_W(CODE_W), .TRIM_W(TRIM_W)) i_refcal_ctrl (
    .clk(clk), .rst(rst), .cal_start(cal_start), .conv_done(conv_done),
    .conv_code(conv_code), .conv_req(conv_req), .pat_bus(pat_bus),
    .trim_a(trim_a), .trim_b(trim_b), .ref_done(ref_done),
    .normal_op(normal_op), .sat_err(sat_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [CODE_W-1:0] model_code(input logic [2:0] p);
    int c, good;
    if (!p[0]) return p[1] ? CODE_W'(TGT_B) : CODE_W'(TGT_A);
    if (!p[1]) begin
      if (cur_alt_at >= 0 && int'(trim_a) <= cur_alt_at) alt_hit = 1'b1;
      good = alt_hit ? cur_alt_good : cur_ga;
      c = TGT_A + int'(trim_a) - good;
    end else begin
      c = TGT_B + int'(trim_b) - cur_gb;
    end
    if (c < 0) c = 0;
    if (c > (1 << CODE_W) - 1) c = (1 << CODE_W) - 1;
    return CODE_W'(c);
  endfunction

  // converter model: answers each request LAT cycles later
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_req && !rst) begin
        logic [2:0] p;
        p = pat_bus;
        repeat (LAT) @(negedge clk);
        conv_code = model_code(p);
        conv_done = 1'b1;
      end
    end
  end

  // pattern monitor (R3, R6)
  always @(negedge clk) begin
    if (!rst && conv_req) begin
      req_cnt++;
      if (!pat_bus[2] || pat_bus[0] != exp_rough) phase_err++;
      if (pat_bus[1] && !ref_done[0]) phase_err++;
      exp_rough = ~exp_rough;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int wait_cyc, req_snap;
      logic [TRIM_W-1:0] ta, tb;
      t = VECS[v];
      cur_ga = t.good_a; cur_gb = t.good_b;
      cur_alt_at = t.alt_at; cur_alt_good = t.alt_good;
      alt_hit = 1'b0;
      @(negedge clk);
      rst = 1'b1; cal_start = 1'b0;
      repeat (4) @(negedge clk);
      req_cnt = 0; phase_err = 0; exp_rough = 1'b0;
      // R1: reset state
      check(trim_a == 8'hFF && trim_b == 8'hFF && pat_bus == 3'b000 && !conv_req &&
            ref_done == 2'b00 && !normal_op && !sat_err, "R1 reset state",
            {trim_a, trim_b}, 16'hFFFF);
      rst = 1'b0;
      repeat (30) @(negedge clk);
      // R2: idle without start
      check(req_cnt == 0, "R2 idle before start", req_cnt, 0);
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      wait_cyc = 0;
      while (!normal_op && !sat_err && wait_cyc < LIMIT) begin
        @(negedge clk);
        wait_cyc++;
      end
      check(wait_cyc < LIMIT, "watchdog", wait_cyc, LIMIT);
      repeat (20) @(negedge clk);
      req_snap = req_cnt;
      ta = trim_a; tb = trim_b;
      check(int'(trim_a) == t.exp_a, "R5 trim_a final", trim_a, t.exp_a);
      check(int'(trim_b) == t.exp_b, "R5 trim_b final", trim_b, t.exp_b);
      check(int'(ref_done) == t.exp_done, "R4 ref_done", ref_done, t.exp_done);
      check(int'(normal_op) == t.exp_norm, "R6 normal_op", normal_op, t.exp_norm);
      check(int'(sat_err) == t.exp_err, "R7 sat_err", sat_err, t.exp_err);
      check(phase_err == 0, "R3 R6 pattern order", phase_err, 0);
      check(pat_bus == 3'b000, "R6 R7 pattern idle at end", pat_bus, 0);
      // R8: start ignored after completion or halt
      cal_start = 1'b1;
      repeat (3) @(negedge clk);
      cal_start = 1'b0;
      repeat (30) @(negedge clk);
      check(req_cnt == req_snap && trim_a == ta && trim_b == tb,
            "R8 start ignored, trims held", req_cnt - req_snap, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule